// File: doc/BRIEF.md
# SPI Master Interrupt Status Unit

This block collects the interrupt sources of a SPI master controller and turns them into one level-sensitive interrupt line. It has two kinds of status bit. Three bits are sticky: they latch single-cycle event strobes for transmit underflow, receive overflow and mode fault, and they hold until software clears them. The other four are live: they are recomputed every cycle from the transmit and receive FIFO occupancy counts, compared with two thresholds that software can program.

Software reaches the block through a small word-select register port. Reading the status word returns all seven bits and clears the sticky ones, and writing ones to the status word clears the chosen sticky bits. The interrupt mask has separate set and clear words and cannot be written directly. While the controller runs in linear (memory-mapped) read mode, the status bits are frozen and events are dropped, so traffic generated by the hardware itself does not raise interrupts.

The block has no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `spi_irq_status_unit`

## Requirements
- R1: Status bit 2 is 1 exactly when the TX count is strictly less than the TX threshold. Live bits follow the counts one clock after the counts are presented.
- R2: Status bit 4 is 1 exactly when the RX count is greater than or equal to the RX threshold.
- R3: Status bit 5 is 1 when the RX count equals FIFO_DEPTH, and bit 3 is 1 when the TX count equals FIFO_DEPTH.
- R4: A strobe on ev_tx_underflow, ev_mode_fail or ev_rx_overflow sets status bit 6, 1 or 0 respectively on the next clock, and the bit holds until it is cleared.
- R5: A read of the status word (reg_sel 0) returns the 7-bit word in reg_rdata[6:0] in the same cycle and clears bits 6, 1 and 0. Live bits keep tracking the FIFO state.
- R6: A write to the status word clears each sticky bit whose reg_wdata bit is 1 and leaves every other bit unchanged.
- R7: A write to the enable word (reg_sel 1) ORs reg_wdata[6:0] into the mask. A write to the disable word (reg_sel 2) clears the matching mask bits. The mask (reg_sel 3) reads back and ignores writes.
- R8: irq is 1 exactly when some bit is set in both the mask and the status word.
- R9: An event strobe in the same cycle as a read-clear or write-one-clear of its bit leaves the bit set.
- R10: While lin_mode is 1, the live bits hold their value and event strobes set nothing.
- R11: Reset clears the status and mask words, drives irq low and sets both thresholds to 1.
- R12: The TX threshold (reg_sel 4) and the RX threshold (reg_sel 5) take reg_wdata[CNT_W-1:0] when written and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lin_mode | input | 1 | Linear-read mode active; freezes the status |
| ev_tx_underflow | input | 1 | Single-cycle TX underflow event |
| ev_rx_overflow | input | 1 | Single-cycle RX overflow event |
| ev_mode_fail | input | 1 | Single-cycle mode-fault event |
| tx_level | input | CNT_W | TX FIFO occupancy |
| rx_level | input | CNT_W | RX FIFO occupancy |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Word select: 0 status, 1 enable, 2 disable, 3 mask, 4 TX threshold, 5 RX threshold |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Read data for the selected word; zero when reg_rd is low |
| irq | output | 1 | Interrupt line |

## Verification
An event strobe can arrive in the same cycle as a clear of its own sticky bit, whether by a status read or by a write-one-clear. The bench asserts the strobe and the register access on the same clock edge. It first checks that the read data shows the word as it was before that edge, and a later read then must show the bit still set. A second pairing applies the freeze and an event strobe together, with the FIFO counts changed in the same window. The bench then checks that the status word has not moved and that the interrupt line stayed low.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int IRQ_W = 7;

  // status bit positions (software decodes these)
  localparam int ST_RX_OVER   = 0;
  localparam int ST_MODE_FAIL = 1;
  localparam int ST_TX_LOW    = 2;
  localparam int ST_TX_FULL   = 3;
  localparam int ST_RX_HIGH   = 4;
  localparam int ST_RX_FULL   = 5;
  localparam int ST_TX_UNDER  = 6;

  localparam int N_STICKY = 3;
  localparam int N_LIVE   = 4;

  typedef enum logic [2:0] {
    SEL_STATUS  = 3'd0,
    SEL_ENABLE  = 3'd1,
    SEL_DISABLE = 3'd2,
    SEL_MASK    = 3'd3,
    SEL_TX_THR  = 3'd4,
    SEL_RX_THR  = 3'd5
  } csr_sel_e;

endpackage

// File: rtl/irq_live_eval.sv
module irq_live_eval #(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_thr,
  input  logic [CNT_W-1:0] rx_thr,
  // {rx_full, rx_high, tx_full, tx_low}
  output logic [3:0]       live_q
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [3:0] live_d;

  always_comb begin
    live_d[3] = (rx_level == FULL_CNT);
    live_d[2] = (rx_level >= rx_thr);
    live_d[1] = (tx_level == FULL_CNT);
    live_d[0] = (tx_level <  tx_thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      live_q <= '0;
    else if (!freeze)
      live_q <= live_d;
  end

endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    // an event in the clearing cycle wins
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bit_q <= 1'b0;
      else
        bit_q <= (bit_q & ~clr[i]) | (ev[i] & ~freeze);
    end
    assign q[i] = bit_q;
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask_q
);

  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;

  assign set_v = set_en ? bits : '0;
  assign clr_v = clr_en ? bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else
      mask_q <= (mask_q | set_v) & ~clr_v;
  end

endmodule

// File: rtl/irq_csr_port.sv
module irq_csr_port
  import spi_irq_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [IRQ_W-1:0]  status_word,
  input  logic [IRQ_W-1:0]  mask_word,
  output logic [IRQ_W-1:0]  status_clr,
  output logic              mask_set,
  output logic              mask_clr,
  output logic [CNT_W-1:0]  tx_thr,
  output logic [CNT_W-1:0]  rx_thr,
  output logic [WORD_W-1:0] reg_rdata
);

  csr_sel_e sel;
  assign sel = csr_sel_e'(reg_sel);

  logic wr_status, rd_status;
  assign wr_status = reg_wr && (sel == SEL_STATUS);
  assign rd_status = reg_rd && (sel == SEL_STATUS);

  always_comb begin
    if (rd_status)
      status_clr = '1;
    else if (wr_status)
      status_clr = reg_wdata[IRQ_W-1:0];
    else
      status_clr = '0;
  end

  assign mask_set = reg_wr && (sel == SEL_ENABLE);
  assign mask_clr = reg_wr && (sel == SEL_DISABLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr <= CNT_W'(1);
      rx_thr <= CNT_W'(1);
    end else if (reg_wr) begin
      if (sel == SEL_TX_THR) tx_thr <= reg_wdata[CNT_W-1:0];
      if (sel == SEL_RX_THR) rx_thr <= reg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (sel)
        SEL_STATUS: reg_rdata = WORD_W'(status_word);
        SEL_MASK:   reg_rdata = WORD_W'(mask_word);
        SEL_TX_THR: reg_rdata = WORD_W'(tx_thr);
        SEL_RX_THR: reg_rdata = WORD_W'(rx_thr);
        default:    reg_rdata = '0;
      endcase
    end
  end

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata;

endmodule

// File: rtl/spi_irq_status_unit.sv
module spi_irq_status_unit
  import spi_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int WORD_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lin_mode,
  input  logic              ev_tx_underflow,
  input  logic              ev_rx_overflow,
  input  logic              ev_mode_fail,
  input  logic [CNT_W-1:0]  tx_level,
  input  logic [CNT_W-1:0]  rx_level,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq
);

  logic [IRQ_W-1:0]    status_word;
  logic [IRQ_W-1:0]    mask_word;
  logic [IRQ_W-1:0]    status_clr;
  logic                mask_set, mask_clr;
  logic [CNT_W-1:0]    tx_thr, rx_thr;
  logic [N_LIVE-1:0]   live_q;
  logic [N_STICKY-1:0] sticky_q;
  logic [N_STICKY-1:0] sticky_ev;
  logic [N_STICKY-1:0] sticky_clr;

  irq_csr_port #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .status_word (status_word),
    .mask_word   (mask_word),
    .status_clr  (status_clr),
    .mask_set    (mask_set),
    .mask_clr    (mask_clr),
    .tx_thr      (tx_thr),
    .rx_thr      (rx_thr),
    .reg_rdata   (reg_rdata)
  );

  irq_live_eval #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_live (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (lin_mode),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .tx_thr   (tx_thr),
    .rx_thr   (rx_thr),
    .live_q   (live_q)
  );

  assign sticky_ev  = {ev_tx_underflow, ev_mode_fail, ev_rx_overflow};
  assign sticky_clr = {status_clr[ST_TX_UNDER], status_clr[ST_MODE_FAIL],
                       status_clr[ST_RX_OVER]};

  irq_sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .freeze (lin_mode),
    .ev     (sticky_ev),
    .clr    (sticky_clr),
    .q      (sticky_q)
  );

  irq_mask_reg #(.W(IRQ_W)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (mask_set),
    .clr_en (mask_clr),
    .bits   (reg_wdata[IRQ_W-1:0]),
    .mask_q (mask_word)
  );

  always_comb begin
    status_word               = '0;
    status_word[ST_RX_OVER]   = sticky_q[0];
    status_word[ST_MODE_FAIL] = sticky_q[1];
    status_word[ST_TX_UNDER]  = sticky_q[2];
    status_word[ST_TX_LOW]    = live_q[0];
    status_word[ST_TX_FULL]   = live_q[1];
    status_word[ST_RX_HIGH]   = live_q[2];
    status_word[ST_RX_FULL]   = live_q[3];
  end

  assign irq = |(status_word & mask_word);

endmodule

// File: rtl/spi_irq_status_unit_chk.sv
module spi_irq_status_unit_chk
  import spi_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             lin_mode,
  input logic             ev_tx_underflow,
  input logic             ev_rx_overflow,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_sel,
  input logic [IRQ_W-1:0] wr_bits,
  input logic [IRQ_W-1:0] status_word,
  input logic [IRQ_W-1:0] mask_word,
  input logic             irq
);

  logic st_rd, st_wr;
  assign st_rd = reg_rd && (reg_sel == 3'(SEL_STATUS));
  assign st_wr = reg_wr && (reg_sel == 3'(SEL_STATUS));

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!lin_mode && ev_rx_overflow) |=> status_word[ST_RX_OVER]); // R9

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[ST_MODE_FAIL] && !st_rd && !(st_wr && wr_bits[ST_MODE_FAIL]))
      |=> status_word[ST_MODE_FAIL]); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !ev_tx_underflow) |=> !status_word[ST_TX_UNDER]); // R5

  AST_LIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lin_mode |=> $stable(status_word[ST_RX_FULL:ST_TX_LOW])); // R10

  AST_NO_EVENT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_mode && !status_word[ST_TX_UNDER]) |=> !status_word[ST_TX_UNDER]); // R10

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'(SEL_ENABLE))
      |=> ((mask_word & $past(wr_bits)) == $past(wr_bits))); // R7

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'(SEL_DISABLE))
      |=> ((mask_word & $past(wr_bits)) == '0)); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_word == '0) |-> !irq); // R8

endmodule

bind spi_irq_status_unit spi_irq_status_unit_chk i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .lin_mode        (lin_mode),
  .ev_tx_underflow (ev_tx_underflow),
  .ev_rx_overflow  (ev_rx_overflow),
  .reg_wr          (reg_wr),
  .reg_rd          (reg_rd),
  .reg_sel         (reg_sel),
  .wr_bits         (reg_wdata[6:0]),
  .status_word     (status_word),
  .mask_word       (mask_word),
  .irq             (irq)
);

// File: tb/test_spi_irq_status_unit.sv
module test_spi_irq_status_unit;

  localparam int DEPTH = 32;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int WW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lin_mode = 1'b0;
  logic          ev_tx_underflow = 1'b0;
  logic          ev_rx_overflow = 1'b0;
  logic          ev_mode_fail = 1'b0;
  logic [CW-1:0] tx_level = CW'(5);
  logic [CW-1:0] rx_level = '0;
  logic          reg_wr = 1'b0;
  logic          reg_rd = 1'b0;
  logic [2:0]    reg_sel = '0;
  logic [WW-1:0] reg_wdata = '0;
  logic [WW-1:0] reg_rdata;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  spi_irq_status_unit #(.FIFO_DEPTH(DEPTH), .WORD_W(WW)) i_spi_irq_status_unit (
    .clk             (clk),
    .rst_n           (rst_n),
    .lin_mode        (lin_mode),
    .ev_tx_underflow (ev_tx_underflow),
    .ev_rx_overflow  (ev_rx_overflow),
    .ev_mode_fail    (ev_mode_fail),
    .tx_level        (tx_level),
    .rx_level        (rx_level),
    .reg_wr          (reg_wr),
    .reg_rd          (reg_rd),
    .reg_sel         (reg_sel),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .irq             (irq)
  );

  localparam logic [2:0] S_STAT = 3'd0, S_EN = 3'd1, S_DIS = 3'd2,
                         S_MASK = 3'd3, S_TXT = 3'd4, S_RXT = 3'd5;

  task automatic chk(input string req, input string what,
                     input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [WW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [WW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = s;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic levels(input int tx, input int rx);
    @(negedge clk);
    tx_level = CW'(tx); rx_level = CW'(rx);
  endtask

  task automatic pulse(input logic u, input logic m, input logic o);
    @(negedge clk);
    ev_tx_underflow = u; ev_mode_fail = m; ev_rx_overflow = o;
    @(negedge clk);
    ev_tx_underflow = 1'b0; ev_mode_fail = 1'b0; ev_rx_overflow = 1'b0;
  endtask

  task automatic t_reset;
    logic [WW-1:0] d;
    rd(S_STAT, d); chk("R11", "status in reset", d, 8'h00);
    rd(S_MASK, d); chk("R11", "mask in reset", d, 8'h00);
    rd(S_TXT, d);  chk("R11", "tx threshold in reset", d, 8'h01);
    rd(S_RXT, d);  chk("R11", "rx threshold in reset", d, 8'h01);
    chk("R11", "irq in reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_thresholds;
    logic [WW-1:0] d;
    wr(S_TXT, 8'd8);
    rd(S_TXT, d); chk("R12", "tx threshold readback", d, 8'd8);
    levels(7, 0);
    rd(S_STAT, d); chk("R1", "tx 7 < thr 8", d, 8'h04);
    levels(8, 0);
    rd(S_STAT, d); chk("R1", "tx 8 not < thr 8", d, 8'h00);
    wr(S_RXT, 8'd3);
    rd(S_RXT, d); chk("R12", "rx threshold readback", d, 8'd3);
    levels(8, 2);
    rd(S_STAT, d); chk("R2", "rx 2 below thr 3", d, 8'h00);
    levels(8, 3);
    rd(S_STAT, d); chk("R2", "rx 3 equals thr 3", d, 8'h10);
    levels(8, 4);
    rd(S_STAT, d); chk("R2", "rx 4 above thr 3", d, 8'h10);
    wr(S_TXT, 8'd1); wr(S_RXT, 8'd1);
    levels(5, 0);
  endtask

  task automatic t_full;
    logic [WW-1:0] d;
    levels(5, DEPTH);
    rd(S_STAT, d); chk("R3", "rx full", d, 8'h30);
    levels(DEPTH, 0);
    rd(S_STAT, d); chk("R3", "tx full", d, 8'h08);
    levels(5, DEPTH - 1);
    rd(S_STAT, d); chk("R3", "rx one short of full", d, 8'h10);
    levels(5, 0);
  endtask

  task automatic t_sticky;
    logic [WW-1:0] d;
    pulse(1'b0, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    rd(S_STAT, d); chk("R4", "rx overflow latched", d, 8'h01);
    rd(S_STAT, d); chk("R5", "cleared by read", d, 8'h00);
    pulse(1'b1, 1'b1, 1'b1);
    rd(S_STAT, d); chk("R4", "all events latched", d, 8'h43);
    pulse(1'b0, 1'b1, 1'b0);
    levels(0, 0);
    rd(S_STAT, d); chk("R5", "sticky plus live", d, 8'h06);
    rd(S_STAT, d); chk("R5", "live stays after read", d, 8'h04);
    levels(5, 0);
  endtask

  task automatic t_w1c;
    logic [WW-1:0] d;
    pulse(1'b1, 1'b1, 1'b1);
    wr(S_STAT, 8'h02);
    rd(S_STAT, d); chk("R6", "only mode fail cleared", d, 8'h41);
  endtask

  task automatic t_mask;
    logic [WW-1:0] d;
    wr(S_EN, 8'h05);
    rd(S_MASK, d); chk("R7", "enable sets", d, 8'h05);
    wr(S_EN, 8'h40);
    rd(S_MASK, d); chk("R7", "enable ORs", d, 8'h45);
    wr(S_DIS, 8'h04);
    rd(S_MASK, d); chk("R7", "disable clears", d, 8'h41);
    wr(S_MASK, 8'h7F);
    rd(S_MASK, d); chk("R7", "mask write ignored", d, 8'h41);
    wr(S_DIS, 8'h7F);
    rd(S_MASK, d); chk("R7", "disable all", d, 8'h00);
  endtask

  task automatic t_irq;
    logic [WW-1:0] d;
    pulse(1'b0, 1'b0, 1'b1);
    chk("R8", "irq low when unmasked", {7'd0, irq}, 8'h00);
    wr(S_EN, 8'h01);
    chk("R8", "irq high on masked sticky", {7'd0, irq}, 8'h01);
    rd(S_STAT, d);
    chk("R8", "irq low after read clear", {7'd0, irq}, 8'h00);
    wr(S_EN, 8'h04);
    levels(0, 0);
    @(negedge clk);
    chk("R8", "irq from live tx low", {7'd0, irq}, 8'h01);
    levels(5, 0);
    @(negedge clk);
    chk("R8", "irq drops with live bit", {7'd0, irq}, 8'h00);
    wr(S_DIS, 8'h7F);
  endtask

  task automatic t_race;
    logic [WW-1:0] d;
    @(negedge clk);
    ev_rx_overflow = 1'b1; reg_rd = 1'b1; reg_sel = S_STAT;
    #1 d = reg_rdata;
    chk("R9", "read data before edge", d, 8'h00);
    @(negedge clk);
    ev_rx_overflow = 1'b0; reg_rd = 1'b0;
    rd(S_STAT, d); chk("R9", "event survives read clear", d, 8'h01);
    pulse(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    ev_mode_fail = 1'b1; reg_wr = 1'b1; reg_sel = S_STAT; reg_wdata = 8'h02;
    @(negedge clk);
    ev_mode_fail = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(S_STAT, d); chk("R9", "event survives w1c", d, 8'h02);
  endtask

  task automatic t_linear;
    logic [WW-1:0] d;
    wr(S_EN, 8'h7F);
    @(negedge clk);
    lin_mode = 1'b1;
    levels(0, DEPTH);
    pulse(1'b1, 1'b1, 1'b1);
    rd(S_STAT, d); chk("R10", "frozen, events dropped", d, 8'h00);
    chk("R10", "irq stays low frozen", {7'd0, irq}, 8'h00);
    @(negedge clk);
    lin_mode = 1'b0;
    rd(S_STAT, d); chk("R10", "live updates after unfreeze", d, 8'h34);
    @(negedge clk);
    lin_mode = 1'b1;
    levels(5, 0);
    rd(S_STAT, d); chk("R10", "live held at old value", d, 8'h34);
    @(negedge clk);
    lin_mode = 1'b0;
    rd(S_STAT, d); chk("R10", "released", d, 8'h00);
    wr(S_DIS, 8'h7F);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_thresholds();
    t_full();
    t_sticky();
    t_w1c();
    t_mask();
    t_irq();
    t_race();
    t_linear();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule